// File: doc/BRIEF.md
# Serial Accumulating Bit Adder

This block adds two unsigned N-bit words one bit pair per clock. An accumulator register supplies one addend from its low end, and its top end takes each new sum bit. An operand register supplies the other addend in the same way. While the operand register drains into the adder, it takes the next operand bit by bit on a serial input, so a stream of operands can be summed back to back. A single stored carry links the bit positions within a pass.

A one-cycle `start` pulse begins a pass of N enabled clocks. `busy` stays high for the whole pass. `done` pulses when the pass finishes, and `carry_out` then shows the carry out of that pass's addition. The stored carry is zeroed at each start, so each pass computes (accumulator + operand) mod 2^N. The first pass only loads the first operand, because both registers hold zero after clear. Each later pass adds in the operand that was fed during the pass before it.

Top module: `serial_accum_adder`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator, operand register, stored carry, bit counter, `done` and `carry_out` all become zero. `rst` takes priority over every other input.
- R2: A `start` pulse seen while `busy` is low zeroes the stored carry and raises `busy` from the next cycle. A `start` seen while `busy` is high is ignored and does not lengthen the pass.
- R3: On each enabled pass clock, the low bits of both registers and the stored carry form a full-adder sum. That sum bit enters the accumulator's top bit, both registers shift right one place, and the adder's carry becomes the new stored carry.
- R4: On each enabled pass clock, `ser_in` enters the operand register's top bit. After a pass, the first bit fed sits at bit 0, so operand words are fed least significant bit first.
- R5: A pass lasts exactly N clocks in which `shift_en` is high. `busy` falls, and `done` is high for one cycle, right after the last of them.
- R6: When `shift_en` is low during a pass, the accumulator, operand register, carry and count all hold, and `busy` stays high.
- R7: After a pass, `acc_q` equals (accumulator before + operand register before) mod 2^N. `carry_out` equals bit N of that sum and holds it until the next pass ends.
- R8: While `busy` is low, `shift_en` and `ser_in` have no effect on either register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous clear, active high |
| shift_en | input | 1 | Allows one bit step during a pass |
| ser_in | input | 1 | Serial operand bit, LSB first |
| start | input | 1 | One-cycle pulse that begins a pass |
| busy | output | 1 | High while a pass is in progress |
| done | output | 1 | One-cycle pulse at the end of a pass |
| acc_q | output | N | Accumulator contents |
| carry_out | output | 1 | Final carry of the last completed pass |

## Verification
A wrong stored carry or a misplaced sum bit shows up in `acc_q` at the `done` cycle of the same pass. A fault in the operand register stays hidden for one pass and shows up only as a wrong total at the end of the next one. For that reason the bench checks every pass of a chained sequence against a running reference. A fault in the count or in the start gating shows up at once as `busy` or `done` at the wrong cycle. Pauses and stray starts are placed inside passes so that these faults are exposed.

// File: rtl/serial_accum_adder.sv
module serial_accum_adder #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         ser_in,
  input  logic         start,
  output logic         busy,
  output logic         done,
  output logic [N-1:0] acc_q,
  output logic         carry_out
);
  localparam int CW = $clog2(N + 1);

  logic [N-1:0]  a_q, b_q;
  logic          c_q, done_q, cout_q;
  logic [CW-1:0] cnt_q;

  wire step     = busy && shift_en;
  wire sum_bit  = a_q[0] ^ b_q[0] ^ c_q;
  wire carry_nx = (a_q[0] & b_q[0]) | (c_q & (a_q[0] ^ b_q[0]));

  assign busy      = (cnt_q != '0);
  assign done      = done_q;
  assign acc_q     = a_q;
  assign carry_out = cout_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q    <= '0;
      b_q    <= '0;
      c_q    <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      cout_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy) begin
        cnt_q <= CW'(N);
        c_q   <= 1'b0;
      end else if (step) begin
        a_q   <= {sum_bit, a_q[N-1:1]};
        b_q   <= {ser_in, b_q[N-1:1]};
        c_q   <= carry_nx;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          done_q <= 1'b1;
          cout_q <= carry_nx;
        end
      end
    end
  end
endmodule

module serial_accum_adder_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         shift_en,
  input logic         ser_in,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [N-1:0] acc_q,
  input logic         carry_out
);
  localparam int EW = $clog2(N + 1) + 1;
  logic [EW-1:0] en_cnt;

  always_ff @(posedge clk) begin
    if (rst || (start && !busy)) en_cnt <= '0;
    else if (busy && shift_en)   en_cnt <= en_cnt + 1'b1;
  end

  a_r1_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (acc_q == '0 && !busy && !done && !carry_out));
  a_r2_start: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy ##1 !done));
  a_r5_count: assert property (@(posedge clk) disable iff (rst)
    done |-> (en_cnt == EW'(N)));
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && !shift_en) |=> (busy && $stable(acc_q)));
  a_r8_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(acc_q));
endmodule

bind serial_accum_adder serial_accum_adder_chk #(.N(N)) chk_i (.*);

// File: tb/serial_accum_adder_tb.sv
module serial_accum_adder_tb_top;
  localparam int N = 8;
  localparam time TCLK = 10ns;
  localparam logic [N-1:0] OPS [8] = '{8'h3C, 8'hA5, 8'hFF, 8'h01, 8'h80, 8'h7E, 8'hC3, 8'h5A};

  logic clk = 0, rst = 1, shift_en = 0, ser_in = 0, start = 0;
  logic busy, done, carry_out;
  logic [N-1:0] acc_q;
  logic [N-1:0] ref_a = '0, ref_b = '0;
  int checks = 0, fails = 0;

  serial_accum_adder #(.N(N)) dut_i (.*);

  always #(TCLK/2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_pass(input logic [N-1:0] op, input int pause_at, input int restart_at);
    logic [N:0] s;
    logic [N-1:0] hold;
    s = {1'b0, ref_a} + {1'b0, ref_b};
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk("R2 busy after start", busy, 1);
    for (int i = 0; i < N; i++) begin
      if (i == pause_at) begin
        shift_en = 0;
        hold = acc_q;
        repeat (3) @(negedge clk);
        chk("R6 acc held", acc_q, hold);
        chk("R6 busy held", busy, 1);
      end
      shift_en = 1; ser_in = op[i]; start = (i == restart_at);
      @(negedge clk) start = 0;
      if (i < N-1) chk("R5 mid-pass busy/done", {busy, done}, 2'b10);
    end
    shift_en = 0; ser_in = 0;
    chk("R5 end busy/done", {busy, done}, 2'b01);
    chk("R7 R3 R4 acc sum", acc_q, s[N-1:0]);
    chk("R7 carry_out", carry_out, s[N]);
    ref_a = s[N-1:0]; ref_b = op;
    @(negedge clk);
    chk("R5 done one cycle", done, 0);
    chk("R7 carry_out held", carry_out, s[N]);
  endtask

  initial begin
    #(TCLK * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 0;
    chk("R1 reset state", {acc_q, busy, done, carry_out}, '0);
    foreach (OPS[k]) run_pass(OPS[k], (k == 2) ? 4 : -1, (k == 3) ? 2 : -1);
    run_pass('0, 0, 6);
    // R8: idle stepping attempts must not disturb either register
    shift_en = 1;
    for (int i = 0; i < 5; i++) begin ser_in = i[0]; @(negedge clk); end
    shift_en = 0;
    chk("R8 idle acc unchanged", acc_q, ref_a);
    run_pass(8'hF0, -1, -1);
    run_pass(8'h0F, N-1, -1);
    // R1: clear mid-pass with start also high
    @(negedge clk) start = 1;
    @(negedge clk) start = 0; shift_en = 1; ser_in = 1;
    repeat (3) @(negedge clk);
    rst = 1; start = 1;
    @(negedge clk) rst = 0; start = 0; shift_en = 0;
    chk("R1 clear mid-pass", {acc_q, busy, done, carry_out}, '0);
    ref_a = '0; ref_b = '0;
    run_pass(8'h99, -1, -1);
    run_pass(8'h01, -1, -1);
    run_pass('0, -1, -1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule